// File: doc/BRIEF.md
# I2C Register-Map Target

This block is an I2C target that gives a host controller access to a small bank of 8-bit configuration registers. The host reaches those registers through a stored register pointer. SCL and SDA are brought into the system clock domain through a synchroniser and edge detector. Start and stop conditions are then recognised from the relative timing of the two lines. The first byte after a start carries a 7-bit device address and a direction bit. The device address joins a fixed five-bit prefix with two strap inputs, which are captured when reset is released.

In a write transfer, the byte after the address loads the pointer and an auto-increment flag. Any bytes that follow are stored starting at that register. In a read transfer, the block returns the register at the pointer, most significant bit first. If auto-increment is on, the next register follows after each host ACK. The usual way to read is to send a short write that stops right after the pointer byte, then start a read. The SDA pad is open-drain, so the block only ever asserts an output-enable that pulls the line low.

Top module: `i2c_regmap_target`

## Requirements
- R1: While reset is high, and on the cycle after it, SDA is released (`sda_oe` = 0) and the target ignores the bus until a start condition.
- R2: An SDA fall while SCL is high is a start and restarts address reception from any state, including in mid-transfer (repeated start). An SDA rise while SCL is high is a stop, which releases SDA and returns the target to idle.
- R3: The target acknowledges an address byte (it pulls SDA low during the ninth SCL pulse) when bits 7:3 of that byte equal the prefix 10011 and bits 2:1 equal the latched straps, with `strap_lo[1]` on bit 2 and `strap_lo[0]` on bit 1. Bit 0 selects the direction, and 1 means read.
- R4: After an address that does not match, the target acknowledges nothing and writes nothing until the next start.
- R5: In a write, the byte after the address is the pointer byte. Bit 7 is the auto-increment flag and bits 4:0 select one of 32 registers. The target acknowledges the pointer byte and every data byte. A stop right after the pointer byte leaves the pointer set for a later read.
- R6: Each data byte in a write is stored at the pointer. With auto-increment on, the pointer then advances by one and wraps from 31 to 0. With it off, the pointer stays where it is, so later bytes overwrite the same register.
- R7: In a read, the target shifts out the register at the pointer, MSB first, and changes SDA only while SCL is low. A read never moves the pointer unless auto-increment is on.
- R8: After each byte it sends, the target samples the host's acknowledge. On an ACK (low) it sends the next register. On a NACK (high) it releases SDA and stays silent until a stop or a repeated start.
- R9: The strap values are captured only while reset is asserted. Changing `strap_lo` after reset is released does not change the device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps captured while high |
| strap_lo | input | 2 | Low two device-address bits, latched at reset release |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | Registered enable that pulls SDA low when 1 |

## Verification
The bench uses the default parameters: a 32-entry bank, prefix 10011 and two synchroniser stages. With 32 entries, a short burst that starts at register 31 reaches the pointer wrap. The bench holds each SCL phase for several system clocks, well beyond the synchroniser latency. This lets it watch address matching with the straps changed after reset, pointer preambles ended by stop and by repeated start, and host NACK handling, all at the pins.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MAP,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_HACK,
    ST_TXLOAD,
    ST_WAIT
  } st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_ff[SYNC_STAGES-1];
      sda_p  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target #(
  parameter int         REG_AW      = 5,
  parameter logic [4:0] DEV_PREFIX  = 5'b10011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_lo,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe
);
  import i2c_cfg_pkg::*;
  localparam int DW  = 8;
  localparam int BW  = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_t  st, nxt;
  logic [BW-1:0]     bitcnt;
  logic [DW-1:0]     sh, tx, rd_q, byte_in;
  logic [REG_AW-1:0] ptr;
  logic              inc_q, ack_on;
  logic [1:0]        dev_lo;
  logic              rx_st, rx_done, addr_hit, map_load, bank_we;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_cfg_bank #(.AW(REG_AW), .DW(DW)) u_bank (
    .clk(clk), .we(bank_we), .addr(ptr), .wdata(byte_in), .rdata(rd_q)
  );

  assign byte_in  = {sh[DW-2:0], sda_s};
  assign rx_st    = (st == ST_ADDR) || (st == ST_MAP) || (st == ST_WDATA);
  assign rx_done  = rx_st && scl_rise && (bitcnt == LAST_BIT) && !start_det && !stop_det;
  assign addr_hit = (byte_in[7:1] == {DEV_PREFIX, dev_lo});
  assign map_load = rx_done && (st == ST_MAP);
  assign bank_we  = rx_done && (st == ST_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      nxt    <= ST_IDLE;
      sda_oe <= 1'b0;
      bitcnt <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      inc_q  <= 1'b0;
      ack_on <= 1'b0;
      dev_lo <= strap_lo;
    end else if (start_det) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
      ack_on <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      ack_on <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_MAP, ST_WDATA: begin
          if (scl_rise) begin
            sh     <= byte_in;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  st  <= ST_ACK;
                  nxt <= byte_in[0] ? ST_TX : ST_MAP;
                end else begin
                  st <= ST_WAIT;
                end
              end else if (st == ST_MAP) begin
                ptr   <= byte_in[REG_AW-1:0];
                inc_q <= byte_in[DW-1];
                st    <= ST_ACK;
                nxt   <= ST_WDATA;
              end else begin
                if (inc_q) ptr <= ptr + 1'b1;
                st  <= ST_ACK;
                nxt <= ST_WDATA;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              bitcnt <= '0;
              st     <= nxt;
              if (nxt == ST_TX) begin
                tx     <= rd_q;
                sda_oe <= ~rd_q[DW-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              st     <= ST_HACK;
              if (inc_q) ptr <= ptr + 1'b1;
            end
          end else if (scl_fall) begin
            tx     <= {tx[DW-2:0], 1'b0};
            sda_oe <= ~tx[DW-2];
          end
        end
        ST_HACK: begin
          if (scl_fall) sda_oe <= 1'b0;
          else if (scl_rise) st <= sda_s ? ST_WAIT : ST_TXLOAD;
        end
        ST_TXLOAD: begin
          if (scl_fall) begin
            tx     <= rd_q;
            sda_oe <= ~rd_q[DW-1];
            bitcnt <= '0;
            st     <= ST_TX;
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regmap_target_chk.sv
module i2c_regmap_target_chk #(
  parameter int REG_AW = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sda_oe,
  input logic                   scl_s,
  input logic                   stop_det,
  input logic                   map_load,
  input logic                   inc_q,
  input logic [REG_AW-1:0]      ptr,
  input i2c_cfg_pkg::st_t       st
);
  import i2c_cfg_pkg::*;

  AST_RESET_RELEASES_SDA: assert property (@(posedge clk) rst |=> !sda_oe); // R1
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe); // R2
  AST_SILENT_AFTER_MISS: assert property (@(posedge clk) disable iff (rst) (st == ST_WAIT) |-> !sda_oe); // R4
  AST_PTR_HOLDS_NO_INC: assert property (@(posedge clk) disable iff (rst) (!map_load && !inc_q) |=> $stable(ptr)); // R6
  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_s); // R7
endmodule

bind i2c_regmap_target i2c_regmap_target_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s), .stop_det(stop_det),
  .map_load(map_load), .inc_q(inc_q), .ptr(ptr), .st(st)
);

// File: tb/test_i2c_regmap_target.sv
module test_i2c_regmap_target;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] strap = 2'b01;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  i2c_regmap_target i_i2c_regmap_target (
    .clk(clk), .rst(rst), .strap_lo(strap), .scl_in(scl_h), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;
  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [7:0] obs_q[$];

  task automatic expect_val(input logic [7:0] v, input string tag);
    exp_v.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_q.push_back(v);
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        logic [7:0] got, want;
        string t;
        got = obs_q.pop_front();
        n_chk++;
        if (exp_v.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected result got=%02h expected=none", got);
        end else begin
          want = exp_v.pop_front();
          t = exp_tag.pop_front();
          if (got !== want) begin
            n_bad++;
            $display("FAIL %s got=%02h expected=%02h", t, got, want);
          end
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(output logic b);
    wait_clk(H);
    scl_h = 1'b1;
    wait_clk(H);
    b = sda_line;
    wait_clk(H);
    scl_h = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_start();
    sda_h = 1'b1;
    wait_clk(H);
    scl_h = 1'b1;
    wait_clk(H);
    sda_h = 1'b0;
    wait_clk(H);
    scl_h = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0;
    wait_clk(H);
    scl_h = 1'b1;
    wait_clk(H);
    sda_h = 1'b1;
    wait_clk(2 * H);
  endtask

  task automatic tx_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic d, a;
    expect_val({7'b0, exp_ack}, tag);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i];
      clk_bit(d);
    end
    sda_h = 1'b1;
    clk_bit(a);
    observe({7'b0, a});
  endtask

  task automatic rx_chk(input logic host_ack, input logic [7:0] exp, input string tag);
    logic d, bt;
    logic [7:0] b;
    expect_val(exp, tag);
    sda_h = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(bt);
      b = {b[6:0], bt};
    end
    sda_h = host_ack;
    clk_bit(d);
    sda_h = 1'b1;
    observe(b);
  endtask

  task automatic oe_chk(input string tag);
    expect_val(8'h00, tag);
    observe({7'b0, sda_oe});
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    oe_chk("R1 reset leaves SDA released");

    // R3 R5 R6: burst write with auto-increment from register 3
    bus_start();
    tx_chk(8'h9A, 1'b0, "R3 address ack");
    tx_chk(8'h83, 1'b0, "R5 pointer byte ack");
    tx_chk(8'hA1, 1'b0, "R6 data ack");
    tx_chk(8'hB2, 1'b0, "R6 data ack");
    tx_chk(8'hC3, 1'b0, "R6 data ack");
    bus_stop();
    oe_chk("R2 stop releases SDA");

    // R5 R7: preamble without increment, read twice same register
    bus_start();
    tx_chk(8'h9A, 1'b0, "R5 address ack");
    tx_chk(8'h03, 1'b0, "R5 pointer ack");
    bus_stop();
    bus_start();
    tx_chk(8'h9B, 1'b0, "R3 read address ack");
    rx_chk(1'b0, 8'hA1, "R7 read register 3");
    rx_chk(1'b1, 8'hA1, "R7 pointer not moved by read");
    bus_stop();

    // R8 R6: auto-increment read burst
    bus_start();
    tx_chk(8'h9A, 1'b0, "R8 address ack");
    tx_chk(8'h83, 1'b0, "R8 pointer ack");
    bus_stop();
    bus_start();
    tx_chk(8'h9B, 1'b0, "R8 read address ack");
    rx_chk(1'b0, 8'hA1, "R8 burst byte 0");
    rx_chk(1'b0, 8'hB2, "R8 burst byte 1");
    rx_chk(1'b1, 8'hC3, "R8 burst byte 2");
    rx_chk(1'b1, 8'hFF, "R8 silent after NACK");
    oe_chk("R8 released after NACK");
    bus_stop();

    // R6: wrap from 31 to 0
    bus_start();
    tx_chk(8'h9A, 1'b0, "R6 address ack");
    tx_chk(8'h9F, 1'b0, "R6 pointer 31 ack");
    tx_chk(8'h11, 1'b0, "R6 data ack");
    tx_chk(8'h22, 1'b0, "R6 data ack");
    bus_stop();
    bus_start();
    tx_chk(8'h9A, 1'b0, "R6 address ack");
    tx_chk(8'h9F, 1'b0, "R6 pointer ack");
    bus_stop();
    bus_start();
    tx_chk(8'h9B, 1'b0, "R6 read address ack");
    rx_chk(1'b0, 8'h11, "R6 register 31");
    rx_chk(1'b1, 8'h22, "R6 wrapped to register 0");
    bus_stop();

    // R6: no increment, writes overwrite one register; R2 repeated start
    bus_start();
    tx_chk(8'h9A, 1'b0, "R6 address ack");
    tx_chk(8'h05, 1'b0, "R6 pointer 5 ack");
    tx_chk(8'h55, 1'b0, "R6 data ack");
    tx_chk(8'h66, 1'b0, "R6 data ack");
    bus_start();
    tx_chk(8'h9B, 1'b0, "R2 repeated start read ack");
    rx_chk(1'b1, 8'h66, "R6 overwrite without increment");
    bus_stop();

    // R4: wrong address, no ack, no write
    bus_start();
    tx_chk(8'h98, 1'b1, "R4 mismatch not acked");
    tx_chk(8'h05, 1'b1, "R4 pointer ignored");
    tx_chk(8'hEE, 1'b1, "R4 data ignored");
    bus_stop();
    bus_start();
    tx_chk(8'h9A, 1'b0, "R4 address ack");
    tx_chk(8'h05, 1'b0, "R4 pointer ack");
    bus_stop();
    bus_start();
    tx_chk(8'h9B, 1'b0, "R4 read address ack");
    rx_chk(1'b1, 8'h66, "R4 register 5 unchanged");
    bus_stop();

    // R9: straps changed after reset have no effect
    strap = 2'b10;
    wait_clk(4);
    bus_start();
    tx_chk(8'h9C, 1'b1, "R9 new strap address not acked");
    bus_stop();
    bus_start();
    tx_chk(8'h9A, 1'b0, "R9 latched address still acked");
    bus_stop();
    oe_chk("R2 idle after stop");

    wait_clk(10);
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      reported = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule